// File: doc/BRIEF.md
# Vector Fixed-Point Requantizer (32-bit to 16-bit)

This block turns signed 32-bit accumulator values, typically the output of a multiply-accumulate array, into signed 16-bit results. Each input beat carries a vector of lanes. Every lane is scaled by a 32-bit fixed-point multiplier and a signed power-of-two shift, saturated to 16 bits, and optionally clamped to a programmable window. The clamp is the fused bounded activation.

The sign of the shift decides where the power-of-two step sits. A negative shift scales the lane up before the fixed-point multiply. A zero or positive shift divides the multiply result afterwards, with rounding to nearest. The datapath has three register stages with a shared stall, and input and output use valid/ready handshakes. The multiplier, shift, clamp enable and bounds are plain configuration inputs. The user holds them steady while any beat is inside the pipeline.

Top module: `requant_s32_s16`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A beat is taken when `in_valid` and `in_ready` are both high at a rising edge. Results leave in the order the beats were taken, with none lost and none repeated.
- R3: The fixed-point multiply forms the signed 64-bit product of a 32-bit value and `cfg_mult`, adds 2^30, shifts right arithmetically by 31 and keeps the low 32 bits. When both operands equal -2^31, the result is 0x7FFFFFFF instead.
- R4: When `cfg_shift` is negative, the lane is first shifted left by |`cfg_shift`| in 32-bit arithmetic (excess high bits are dropped), then multiplied as in R3. No right shift follows.
- R5: When `cfg_shift` is zero or positive, the R3 result is divided by 2^`cfg_shift` and rounded to nearest, with exact halves rounded away from zero. A shift of 0 leaves the value unchanged.
- R6: The scaled 32-bit value saturates to the range -32768..32767.
- R7: When `cfg_clamp_en` is 1, the saturated value is first raised to at least `cfg_lo` and then lowered to at most `cfg_hi`. When `cfg_lo` > `cfg_hi`, every lane therefore yields `cfg_hi`.
- R8: When `cfg_clamp_en` is 0, `cfg_lo` and `cfg_hi` have no effect on the output.
- R9: Lanes are independent. Input lane i occupies `in_data[32*i+31:32*i]` and output lane i occupies `out_data[16*i+15:16*i]`.
- R10: `cfg_shift` is a two's-complement value limited to -31..31, and configuration stays unchanged while any beat is in flight.
- R11: While `out_valid` is 1 and `out_ready` is 0, every stage holds: `out_valid` and `out_data` do not change and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mult | input | 32 | Signed fixed-point multiplier |
| cfg_shift | input | 6 | Signed shift; negative means pre-multiply left shift |
| cfg_clamp_en | input | 1 | Enables the bounded clamp |
| cfg_lo | input | 16 | Signed lower clamp bound |
| cfg_hi | input | 16 | Signed upper clamp bound |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | LANES*32 | Packed signed 32-bit lanes |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer can take a result |
| out_data | output | LANES*16 | Packed signed 16-bit lanes |

## Verification
The hardest case to reach from the ports is the saturating corner of the doubling multiply. It needs both operands at -2^31, and with a negative shift that operand can come from the pre-shift itself, such as -2^30 shifted left by one. The stimulus sets the multiplier to -2^31 and feeds both forms. It also sends the same corner through a shift of 31, so that a wrapped product would show as -1 rather than +1. Exact-half rounding ties for negative values are driven the same way, and every beat passes through a randomly back-pressured output port.

// File: rtl/requant_pkg.sv
// Package: shared widths and types for the requantizer datapath.
// Assumes two's-complement signed data throughout.
package requant_pkg;
    localparam int ACC_W = 32;
    localparam int RES_W = 16;
    localparam int SH_W  = 6;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [RES_W-1:0] res_t;
    typedef logic signed [SH_W-1:0]  shf_t;
    localparam acc_t ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam acc_t ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam res_t RES_MIN = {1'b1, {(RES_W-1){1'b0}}};
    localparam res_t RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
endpackage

// File: rtl/rq_mulhi.sv
// Module: optional pre-multiply left shift and rounding doubling high-half
// multiply for one lane. Purely combinational.
// Assumes shift lies in -31..31; positive shifts are ignored here.
module rq_mulhi
    import requant_pkg::*;
(
    input  acc_t x,
    input  acc_t mult,
    input  shf_t shift,
    output acc_t y
);
    localparam int PW = 2 * ACC_W;
    localparam int LW = $clog2(ACC_W);

    logic [LW-1:0]       lamt;
    acc_t                xs;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    // Left shift amount is the magnitude of a negative shift, else zero.
    always_comb lamt = shift[SH_W-1] ? LW'(-shift) : '0;

    // Wrapping left shift, full product, rounding constant, high half.
    always_comb begin
        xs   = x <<< lamt;
        prod = PW'(xs) * PW'(mult);
        rnd  = prod + (PW'(1) <<< (ACC_W - 2));
        if (xs == ACC_MIN && mult == ACC_MIN)
            y = ACC_MAX;
        else
            y = ACC_W'(rnd >>> (ACC_W - 1));
    end
endmodule

// File: rtl/rq_rshift.sv
// Module: rounding arithmetic right shift, halves away from zero.
// Assumes shift lies in -31..31; zero or negative shifts pass x through.
module rq_rshift
    import requant_pkg::*;
(
    input  acc_t x,
    input  shf_t shift,
    output acc_t y
);
    localparam int EW = ACC_W + 1;
    localparam int LW = $clog2(ACC_W);

    logic [LW-1:0]        ramt;
    logic signed [EW-1:0] bias;
    logic signed [EW-1:0] sum;

    // Only a positive shift produces a right shift.
    always_comb ramt = shift[SH_W-1] ? '0 : shift[LW-1:0];

    // Add half, less one for negatives, then shift arithmetically.
    always_comb begin
        bias = (EW'(1) <<< ramt) >>> 1;
        sum  = EW'(x) + bias - EW'(x[ACC_W-1] && ramt != '0);
        y    = ACC_W'(sum >>> ramt);
    end
endmodule

// File: rtl/rq_satclamp.sv
// Module: saturate a 32-bit value to 16 bits, then optionally raise it to lo
// and lower it to hi, in that order. Purely combinational.
module rq_satclamp
    import requant_pkg::*;
(
    input  acc_t x,
    input  logic en,
    input  res_t lo,
    input  res_t hi,
    output res_t y
);
    res_t sat;
    res_t low_cut;

    // Saturate to the 16-bit signed range.
    always_comb begin
        if (x > ACC_W'(RES_MAX))      sat = RES_MAX;
        else if (x < ACC_W'(RES_MIN)) sat = RES_MIN;
        else                          sat = RES_W'(x);
    end

    // Max with the lower bound first, then min with the upper bound.
    always_comb begin
        low_cut = (sat < lo) ? lo : sat;
        y       = !en ? sat : ((low_cut > hi) ? hi : low_cut);
    end

    // R6
    always_comb if (!en) sat_range_chk: assert ((x >= ACC_W'(RES_MAX)) || (y != RES_MAX) || (ACC_W'(y) == x));
endmodule

// File: rtl/requant_s32_s16.sv
// Module: top of the vector requantizer. Three register stages with a shared
// stall: (1) pre-shift and multiply, (2) rounding right shift,
// (3) saturate and clamp. Assumes configuration is held steady while any beat
// is in flight and that cfg_shift lies in -31..31.
module requant_s32_s16
    import requant_pkg::*;
#(
    parameter int LANES = 8
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ACC_W-1:0]       cfg_mult,
    input  logic [SH_W-1:0]        cfg_shift,
    input  logic                   cfg_clamp_en,
    input  logic [RES_W-1:0]       cfg_lo,
    input  logic [RES_W-1:0]       cfg_hi,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*ACC_W-1:0] in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LANES*RES_W-1:0] out_data
);
    localparam int STAGES = 3;

    logic [STAGES-1:0] vld;
    logic              adv;
    acc_t [LANES-1:0]  s1_d, s1_q, s2_d, s2_q;
    res_t [LANES-1:0]  s3_d, s3_q;

    // Whole pipeline advances unless the last stage is blocked.
    always_comb adv = !vld[STAGES-1] || out_ready;
    assign in_ready  = adv;
    assign out_valid = vld[STAGES-1];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        rq_mulhi u_mul (
            .x(acc_t'(in_data[i*ACC_W +: ACC_W])),
            .mult(acc_t'(cfg_mult)),
            .shift(shf_t'(cfg_shift)),
            .y(s1_d[i])
        );
        rq_rshift u_shr (
            .x(s1_q[i]),
            .shift(shf_t'(cfg_shift)),
            .y(s2_d[i])
        );
        rq_satclamp u_sat (
            .x(s2_q[i]),
            .en(cfg_clamp_en),
            .lo(res_t'(cfg_lo)),
            .hi(res_t'(cfg_hi)),
            .y(s3_d[i])
        );
        assign out_data[i*RES_W +: RES_W] = s3_q[i];

        // R7
        clamp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && cfg_clamp_en && $signed(cfg_lo) <= $signed(cfg_hi))
            |-> ($signed(s3_q[i]) >= $signed(cfg_lo) && $signed(s3_q[i]) <= $signed(cfg_hi)));
    end

    // Valid bits shift forward on every advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   vld <= '0;
        else if (adv) vld <= {vld[STAGES-2:0], in_valid};
    end

    // Data registers move together with the valid bits.
    always_ff @(posedge clk) begin
        if (adv) begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R11
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));
    // R10
    shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ($signed(cfg_shift) >= -31));
    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|vld) |-> ($stable(cfg_mult) && $stable(cfg_shift) && $stable(cfg_clamp_en)
                    && $stable(cfg_lo) && $stable(cfg_hi)));
endmodule

// File: tb/sim_requant_s32_s16.sv
module sim_requant_s32_s16;
    localparam int L = 8;

    logic clk = 0, rst_n = 0;
    logic [31:0] cfg_mult = 0;
    logic [5:0]  cfg_shift = 0;
    logic        cfg_clamp_en = 0;
    logic [15:0] cfg_lo = 0, cfg_hi = 0;
    logic        in_valid = 0, in_ready, out_valid, out_ready = 0;
    logic [L*32-1:0] in_data = '0;
    logic [L*16-1:0] out_data;

    int checks = 0, errors = 0;
    logic [L*16-1:0] exp_q[$];
    string           tag_q[$];
    bit              bp_on = 0;
    bit              done = 0;

    always #4 clk = ~clk;

    requant_s32_s16 #(.LANES(L)) u0 (.*);

    // Reference model built from the requirement text.
    function automatic int ref_lane(int x);
        longint m, p, r; int sh, v; int mag; longint a;
        sh = $signed(cfg_shift);
        m  = longint'($signed(cfg_mult));
        v  = (sh < 0) ? int'(x <<< (-sh)) : x;                          // R4
        if (v == 32'sh80000000 && m == -64'sd2147483648) r = 2147483647; // R3
        else begin
            p = longint'(v) * m;
            r = longint'(int'((p + 64'sd1073741824) >>> 31));
        end
        if (sh > 0) begin                                               // R5
            a   = (r < 0) ? -r : r;
            a   = (a + (64'sd1 <<< (sh - 1))) >>> sh;
            r   = (r < 0) ? -a : a;
        end
        if (r > 32767) r = 32767;                                       // R6
        if (r < -32768) r = -32768;
        if (cfg_clamp_en) begin                                         // R7
            if (r < longint'($signed(cfg_lo))) r = $signed(cfg_lo);
            if (r > longint'($signed(cfg_hi))) r = $signed(cfg_hi);
        end
        mag = int'(r);
        return mag;
    endfunction

    task automatic send(input int v[L], input string tag);
        logic [L*16-1:0] e;
        for (int i = 0; i < L; i++) e[i*16 +: 16] = 16'(ref_lane(v[i]));
        @(negedge clk);
        for (int i = 0; i < L; i++) in_data[i*32 +: 32] = v[i];
        in_valid = 1;
        forever begin
            #2;
            if (in_ready) break;
            @(negedge clk);
        end
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk);
        #1 in_valid = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || out_valid) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic cfg(input int m, input int s, input bit en, input int lo, input int hi);
        drain();
        cfg_mult = m; cfg_shift = 6'(s); cfg_clamp_en = en; cfg_lo = 16'(lo); cfg_hi = 16'(hi);
    endtask

    // Monitor: drive back-pressure, compare on each handshake, check stall hold.
    initial begin
        logic [L*16-1:0] held; bit was_stall = 0;
        forever begin
            @(negedge clk);
            if (was_stall && rst_n) begin
                checks++;
                if (!out_valid || out_data !== held) begin
                    errors++;
                    $display("FAIL R11 stall hold: got %h valid %b, expected %h", out_data, out_valid, held);
                end
            end
            out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
            #1;
            was_stall = out_valid && !out_ready;
            held = out_data;
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected beat: got %h, expected none", out_data);
                end else begin
                    logic [L*16-1:0] e; string t;
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    if (out_data !== e) begin
                        errors++;
                        $display("FAIL %s: got %h, expected %h", t, out_data, e);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v[L];
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: got valid %b ready %b, expected 0 1", out_valid, in_ready);
        end

        // R9 distinct lanes, halving multiplier
        cfg(32'h40000000, 0, 0, 0, 0);
        v = '{1, -1, 3, -3, 1000, -1000, 65535, -65536};
        send(v, "R9 lane independence");
        // R3 saturating corner, direct and via shift of 31
        cfg(32'h80000000, 0, 0, 0, 0);
        v = '{32'h80000000, 32'h7FFFFFFF, 0, 1, -1, 32'h80000001, 65536, -65536};
        send(v, "R3 doubling multiply corner");
        cfg(32'h80000000, 31, 0, 0, 0);
        v = '{32'h80000000, 32'h7FFFFFFF, 32'h40000000, -5, 7, 0, 32'hC0000000, 1};
        send(v, "R3 corner through shift 31");
        // R4 negative shifts, including wrap and the -2^30 << 1 corner
        cfg(32'h80000000, -1, 0, 0, 0);
        v = '{32'hC0000000, 32'h40000000, 5, -5, 100, 0, 1, -1};
        send(v, "R4 pre-shift corner");
        cfg(32'h7FFFFFFF, -4, 0, 0, 0);
        v = '{32'h10000000, 32'h08000000, 1000, -1000, 2047, -2048, 3, 0};
        send(v, "R4 wrap left shift");
        cfg(32'h7FFFFFFF, -31, 0, 0, 0);
        v = '{1, -1, 0, 2, 3, 32'h7FFFFFFF, 32'h80000000, 4};
        send(v, "R4 shift -31");
        // R5 ties away from zero
        cfg(32'h7FFFFFFF, 1, 0, 0, 0);
        v = '{2, 3, -3, -5, 5, 1, -1, -2};
        send(v, "R5 ties shift 1");
        cfg(32'h40000000, 2, 0, 0, 0);
        v = '{12, -12, 20, -20, 11, -11, 4, -4};
        send(v, "R5 ties shift 2");
        // R6 saturation
        cfg(32'h7FFFFFFF, 0, 0, 0, 0);
        v = '{32768, -32769, 100000, -100000, 32767, -32768, 32'h7FFFFFFF, 32'h80000000};
        send(v, "R6 saturation");
        // R7 clamp, normal and inverted window
        cfg(32'h7FFFFFFF, 0, 1, -100, 200);
        v = '{-500, 500, 0, -100, 200, -101, 201, 50000};
        send(v, "R7 clamp window");
        cfg(32'h7FFFFFFF, 0, 1, 50, -50);
        v = '{0, 100, -100, 50, -50, 32767, -32768, 7};
        send(v, "R7 inverted bounds");
        // R8 bounds ignored when disabled
        cfg(32'h7FFFFFFF, 0, 0, 50, -50);
        v = '{0, 100, -100, 50, -50, 32767, -32768, 7};
        send(v, "R8 clamp disabled");

        // R2 / R11 streams under back-pressure with varied configs
        bp_on = 1;
        for (int g = 0; g < 12; g++) begin
            int s;
            s = int'($urandom_range(0, 62)) - 31;
            cfg(int'($urandom), s, g[0], int'($urandom_range(0, 2000)) - 1000, int'($urandom_range(0, 2000)) - 1000);
            for (int b = 0; b < 20; b++) begin
                for (int i = 0; i < L; i++) v[i] = int'($urandom);
                send(v, "R2 ordered stream");
            end
        end
        drain();
        bp_on = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule